// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM whose control pins are active low: chip select, write enable and output enable. The host offers a request made of a valid flag, a write flag, a 15-bit word address and a byte of write data. The controller takes the request only when it is idle and runs one access on the memory pins. It then pulses a done strobe for one cycle. For a read, the fetched byte is on the read-data port during that cycle and stays there until the next read finishes.

Every phase of an access lasts a whole number of clock cycles. Each count comes from a time limit in picoseconds and the clock period, both parameters: it is the limit divided by the period, rounded up, and never less than one cycle. Reads hold chip select and output enable low for the access window and sample the bus on its last clock. Writes hold output enable high for the whole cycle and lower the write strobe. They wait out a turnaround count before driving the data bus, keep data valid for the setup window, and raise the strobe. The bus is released one cycle later. All memory pins come straight from flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, mem_ncs, mem_nwe and mem_noe are 1, mem_dq_oe is 0 and rsp_done is 0.
- R2: A read request taken in idle holds mem_ncs=0, mem_noe=0 and mem_nwe=1 for the read window. The window is the larger of the access time and the read cycle time, in clock cycles: 10 at a 5 ns clock. mem_addr equals the request address throughout.
- R3: The read byte is sampled from mem_dq_in on the last clock of the read window and appears on rsp_rdata in the done cycle. rsp_rdata changes at no other time.
- R4: A write request taken in idle holds mem_ncs=0 and mem_noe=1 for the whole access, with mem_nwe=0 for the turnaround plus data windows. mem_addr equals the request address throughout.
- R5: During a write, mem_dq_oe stays 0 for the first turnaround-count cycles of the strobe-low time (3 at a 5 ns clock). The turnaround count covers the memory's output-off time.
- R6: mem_dq_oe is 1 and mem_dq_out equals the request data for the data window before mem_nwe rises. The data window is the larger of the data setup count (7) and the pulse count less the turnaround count. The strobe stays low for at least the pulse count (9).
- R7: The cycle in which mem_nwe rises still has mem_ncs=0 and mem_dq_oe=1. The hold count is at least one and covers the write cycle time (1 at a 5 ns clock). After it, chip select rises and the bus is released together.
- R8: rsp_done is high for exactly one cycle per access, in the first cycle of a recovery phase. During recovery mem_ncs=1 for the recovery count (1), and then one idle cycle follows before a new request can be taken.
- R9: req_valid, req_write, req_addr and req_wdata are sampled only in the idle state. Values presented while an access runs have no effect on the memory pins or on the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last read byte |
| rsp_done | output | 1 | One-cycle access completion strobe |
| mem_addr | output | 15 | Memory address pins |
| mem_ncs | output | 1 | Chip select, active low |
| mem_nwe | output | 1 | Write strobe, active low |
| mem_noe | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Data coming from the memory |

## Verification
Two things can meet in one cycle: the done strobe of one access and a host request that is already waiting for the next one. They also meet when a request is held during a busy period with fields that change. The bench keeps req_valid high through write-then-read and read-then-write sequences. It also changes the address, data and direction in the middle of a write. A queue-based model accepts a request only at an idle edge and predicts every pin for every cycle. The bench therefore flags any access that starts in the done or recovery cycle, any write that lands at the changed address, and any read whose data was sampled before the memory's access time had passed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   // Access phases; the encoding carries no meaning outside the sequencer.
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_READ  = 3'd1,
      PH_WTURN = 3'd2,
      PH_WDATA = 3'd3,
      PH_WHOLD = 3'd4,
      PH_RECOV = 3'd5
   } sram_phase_e;

   // Whole clock cycles covering a time limit, never less than one.
   function automatic int unsigned cyc_of(input int unsigned t_ps,
                                          input int unsigned clk_ps);
      int unsigned n;
      n = (t_ps + clk_ps - 1) / clk_ps;
      return (n < 1) ? 1 : n;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Loadable down counter; expired is high in the last cycle of a phase.
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
// Phase sequencer: walks idle -> access phases -> recovery, and registers
// the memory control pins from the next phase so they leave flops directly.
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC   = 10,
   parameter int TA_CYC   = 3,
   parameter int DW_CYC   = 7,
   parameter int HOLD_CYC = 1,
   parameter int REC_CYC  = 1,
   parameter int CNT_W    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic accept,
   output logic capture,
   output logic pin_ncs,
   output logic pin_nwe,
   output logic pin_noe,
   output logic pin_dq_oe,
   output logic done
);

   sram_phase_e      state_q, state_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_exp;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            if (req_valid) begin
               accept   = 1'b1;
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = PH_WTURN;
                  tmr_val = CNT_W'(TA_CYC - 1);
               end else begin
                  state_d = PH_READ;
                  tmr_val = CNT_W'(RD_CYC - 1);
               end
            end
         end
         PH_READ: begin
            if (tmr_exp) begin
               capture  = 1'b1;
               state_d  = PH_RECOV;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(REC_CYC - 1);
            end
         end
         PH_WTURN: begin
            if (tmr_exp) begin
               state_d  = PH_WDATA;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(DW_CYC - 1);
            end
         end
         PH_WDATA: begin
            if (tmr_exp) begin
               state_d  = PH_WHOLD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(HOLD_CYC - 1);
            end
         end
         PH_WHOLD: begin
            if (tmr_exp) begin
               state_d  = PH_RECOV;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(REC_CYC - 1);
            end
         end
         PH_RECOV: begin
            if (tmr_exp) state_d = PH_IDLE;
         end
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PH_IDLE;
         pin_ncs   <= 1'b1;
         pin_nwe   <= 1'b1;
         pin_noe   <= 1'b1;
         pin_dq_oe <= 1'b0;
         done      <= 1'b0;
      end else begin
         state_q   <= state_d;
         pin_ncs   <= !(state_d inside {PH_READ, PH_WTURN, PH_WDATA, PH_WHOLD});
         pin_nwe   <= !(state_d inside {PH_WTURN, PH_WDATA});
         pin_noe   <= (state_d != PH_READ);
         pin_dq_oe <= (state_d inside {PH_WDATA, PH_WHOLD});
         done      <= (state_d == PH_RECOV) && (state_q != PH_RECOV);
      end
   end

endmodule

// File: rtl/sram_ctrl_datapath.sv
// Request latch and read capture register.
module sram_ctrl_datapath #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (capture) begin
         rdata_q <= mem_dq_in;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PS        = 5000,
   parameter int T_RD_ACC_PS   = 50000,
   parameter int T_RD_CYC_PS   = 50000,
   parameter int T_WP_PS       = 45000,
   parameter int T_DS_PS       = 35000,
   parameter int T_TURN_PS     = 15000,
   parameter int T_WC_PS       = 50000,
   parameter int T_REC_PS      = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ncs,
   output logic              mem_nwe,
   output logic              mem_noe,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   // Phase lengths in clock cycles.
   localparam int RD_CYC   = imax(int'(cyc_of(T_RD_ACC_PS, CLK_PS)),
                                  int'(cyc_of(T_RD_CYC_PS, CLK_PS)));
   localparam int WP_CYC   = int'(cyc_of(T_WP_PS, CLK_PS));
   localparam int DS_CYC   = int'(cyc_of(T_DS_PS, CLK_PS));
   localparam int TA_CYC   = int'(cyc_of(T_TURN_PS, CLK_PS));
   localparam int WC_CYC   = int'(cyc_of(T_WC_PS, CLK_PS));
   localparam int REC_CYC  = int'(cyc_of(T_REC_PS, CLK_PS));
   localparam int DW_CYC   = imax(DS_CYC, WP_CYC - TA_CYC);
   localparam int HOLD_CYC = imax(1, WC_CYC - TA_CYC - DW_CYC);
   localparam int LEN_MAX  = imax(imax(RD_CYC, DW_CYC),
                                  imax(imax(TA_CYC, HOLD_CYC), REC_CYC));
   localparam int CNT_W    = imax(1, $clog2(LEN_MAX + 1));

   // Elaboration-time parameter checks.
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: address and data widths must be positive");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("sram_async_ctrl: clock period must be positive");
   end
   if (TA_CYC + DW_CYC < WP_CYC || DW_CYC < DS_CYC) begin : g_bad_wr
      $error("sram_async_ctrl: write windows do not cover pulse or setup");
   end

   logic accept, capture;

   sram_ctrl_seq #(
      .RD_CYC   (RD_CYC),
      .TA_CYC   (TA_CYC),
      .DW_CYC   (DW_CYC),
      .HOLD_CYC (HOLD_CYC),
      .REC_CYC  (REC_CYC),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .accept    (accept),
      .capture   (capture),
      .pin_ncs   (mem_ncs),
      .pin_nwe   (mem_nwe),
      .pin_noe   (mem_noe),
      .pin_dq_oe (mem_dq_oe),
      .done      (rsp_done)
   );

   sram_ctrl_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_in (mem_dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rdata_q   (rsp_rdata)
   );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter int WP_CYC = 9,
   parameter int DS_CYC = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_ncs,
   input logic              mem_nwe,
   input logic              mem_noe,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              rsp_done,
   input logic [DATA_W-1:0] rsp_rdata
);

   logic [15:0] low_cnt, drive_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt   <= '0;
         drive_cnt <= '0;
      end else begin
         low_cnt   <= mem_nwe ? '0 : low_cnt + 1'b1;
         drive_cnt <= (mem_nwe || !mem_dq_oe) ? '0 : drive_cnt + 1'b1;
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ncs |-> (mem_nwe && !mem_dq_oe));

   // R4
   write_noe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_nwe |-> (mem_noe && !mem_ncs));

   // R5
   turn_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_nwe) |-> !mem_dq_oe);

   // R5
   no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_noe);

   // R6
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_nwe) |-> (low_cnt >= 16'(WP_CYC)));

   // R6
   setup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_nwe) |-> (drive_cnt >= 16'(DS_CYC)));

   // R7
   hold_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_nwe) |-> (mem_dq_oe && !mem_ncs));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R8
   done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (mem_ncs && !mem_dq_oe));

   // R3
   rdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata) |-> rsp_done);

   // R9
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> $past(mem_ncs));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WP_CYC (WP_CYC),
   .DS_CYC (DS_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_ncs   (mem_ncs),
   .mem_nwe   (mem_nwe),
   .mem_noe   (mem_noe),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr),
   .rsp_done  (rsp_done),
   .rsp_rdata (rsp_rdata)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

   localparam int CLK    = 5000;
   localparam int RD_T   = (50000 + CLK - 1) / CLK;
   localparam int TA_T   = (15000 + CLK - 1) / CLK;
   localparam int WP_T   = (45000 + CLK - 1) / CLK;
   localparam int DS_T   = (35000 + CLK - 1) / CLK;
   localparam int DW_T   = (DS_T > WP_T - TA_T) ? DS_T : WP_T - TA_T;
   localparam int HO_T   = (10 - TA_T - DW_T > 1) ? 10 - TA_T - DW_T : 1;
   localparam int REC_T  = 1;
   localparam logic [7:0] EMPTY = 8'h3C;  // memory model content never written
   localparam logic [7:0] JUNK  = 8'hEE;  // bus value while not readable

   typedef struct packed {
      logic ncs, nwe, noe, oe, done;
   } pins_t;
   localparam pins_t IDLE_P = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  rsp_rdata, mem_dq_out;
   logic [7:0]  mem_dq_in = JUNK;
   logic        rsp_done, mem_ncs, mem_nwe, mem_noe, mem_dq_oe;
   logic [14:0] mem_addr;

   always #2.5 clk = ~clk;

   sram_async_ctrl u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata),
      .rsp_rdata (rsp_rdata), .rsp_done (rsp_done),
      .mem_addr (mem_addr), .mem_ncs (mem_ncs), .mem_nwe (mem_nwe),
      .mem_noe (mem_noe), .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe),
      .mem_dq_in (mem_dq_in)
   );

   int tests = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL [%s] %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] ram [int];
   int  rd_age = 0;
   logic prev_nwe = 1'b1;

   always @(negedge clk) begin
      if (!mem_ncs && mem_nwe && !mem_noe) rd_age++;
      else rd_age = 0;
      if (rd_age >= RD_T)
         mem_dq_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : EMPTY;
      else
         mem_dq_in = JUNK;
      if (!prev_nwe && mem_nwe && !mem_ncs)
         ram[int'(mem_addr)] = mem_dq_oe ? mem_dq_out : JUNK;
      prev_nwe = mem_nwe;
   end

   // ---------------- reference model ----------------
   pins_t       exp_q[$];
   logic [14:0] cur_addr = '0;
   logic [7:0]  cur_wdata = '0, cur_rexp = '0, model_rdata = '0;
   bit          cur_write = 0;
   bit          acc_seen = 0;
   int          done_seen = 0, txn_count = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q.delete();
      end else if (exp_q.size() != 0) begin
         void'(exp_q.pop_front());
      end else if (req_valid) begin
         cur_addr  = req_addr;
         cur_wdata = req_wdata;
         cur_write = req_write;
         cur_rexp  = ram.exists(int'(req_addr)) ? ram[int'(req_addr)] : EMPTY;
         acc_seen  = 1;
         txn_count++;
         if (req_write) begin
            repeat (TA_T) exp_q.push_back('{1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
            repeat (DW_T) exp_q.push_back('{1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
            repeat (HO_T) exp_q.push_back('{1'b0, 1'b1, 1'b1, 1'b1, 1'b0});
         end else begin
            repeat (RD_T) exp_q.push_back('{1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
         end
         exp_q.push_back('{1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
         repeat (REC_T - 1) exp_q.push_back(IDLE_P);
      end
   end

   always @(negedge clk) begin
      pins_t e, a;
      string tag;
      e = (exp_q.size() != 0) ? exp_q[0] : IDLE_P;
      a = '{mem_ncs, mem_nwe, mem_noe, mem_dq_oe, rsp_done};
      if (e.done && !cur_write) model_rdata = cur_rexp;
      if (rsp_done) done_seen++;
      if (e.done)                   tag = "R8";
      else if (!e.ncs && !e.noe)    tag = "R2";
      else if (!e.nwe && !e.oe)     tag = "R5";
      else if (!e.nwe && e.oe)      tag = "R6";
      else if (!e.ncs && e.oe)      tag = "R7";
      else if (exp_q.size() != 0)   tag = "R8";
      else                          tag = "R1";
      chk(a == e, tag, "pins {ncs,nwe,noe,oe,done}", int'(a), int'(e));
      if (!e.ncs)
         chk(mem_addr == cur_addr, cur_write ? "R4" : "R2", "mem_addr",
             int'(mem_addr), int'(cur_addr));
      if (e.oe)
         chk(mem_dq_out == cur_wdata, "R6", "mem_dq_out",
             int'(mem_dq_out), int'(cur_wdata));
      chk(rsp_rdata == model_rdata, "R3", "rsp_rdata",
          int'(rsp_rdata), int'(model_rdata));
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit w, input int a, input int d);
      req_write = w;
      req_addr  = 15'(a);
      req_wdata = 8'(d);
      req_valid = 1'b1;
      acc_seen  = 0;
      do @(negedge clk); while (!acc_seen);
   endtask

   task automatic go_idle();
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic read_expect(input int a, input int v, input string req);
      issue(0, a, 0);
      go_idle();
      chk(rsp_rdata == 8'(v), req, "read back", int'(rsp_rdata), v);
   endtask

   task automatic run_tests();
      repeat (4) @(negedge clk);
      // R1: reset state
      chk({mem_ncs, mem_nwe, mem_noe, mem_dq_oe, rsp_done} == 5'b11100, "R1",
          "reset pins", int'({mem_ncs, mem_nwe, mem_noe, mem_dq_oe, rsp_done}), 'h1c);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 R5 R6 R7: single writes, boundary addresses and data patterns
      issue(1, 'h0000, 'h00); go_idle();
      issue(1, 'h7FFF, 'hFF); go_idle();
      issue(1, 'h1234, 'hA5); go_idle();
      issue(1, 'h5555, 'h5A); go_idle();

      // R2 R3: reads of written and unwritten words
      read_expect('h7FFF, 'hFF, "R3");
      read_expect('h0000, 'h00, "R3");
      read_expect('h1234, 'hA5, "R2");
      read_expect('h2AAA, EMPTY, "R2");

      // R8: valid held high, write then read then write, back to back
      issue(1, 'h0042, 'hC3);
      issue(0, 'h0042, 0);
      issue(1, 'h0043, 'h81);
      issue(0, 'h5555, 0);
      go_idle();
      chk(rsp_rdata == 8'h5A, "R3", "back-to-back read", int'(rsp_rdata), 'h5A);
      read_expect('h0042, 'hC3, "R8");
      read_expect('h0043, 'h81, "R8");

      // R3: read data holds across a later write
      issue(1, 'h0100, 'h77); go_idle();
      chk(rsp_rdata == 8'h81, "R3", "rdata held over write", int'(rsp_rdata), 'h81);

      // R9: fields changed while busy are ignored
      issue(1, 'h0200, 'h11);
      req_addr  = 15'h0300;
      req_wdata = 8'h22;
      repeat (4) @(negedge clk);
      req_write = 1'b0;
      req_addr  = 15'h0100;
      repeat (2) @(negedge clk);
      go_idle();
      chk(ram.exists('h0200) && ram['h0200] == 8'h11, "R9", "written word",
          ram.exists('h0200) ? int'(ram['h0200]) : -1, 'h11);
      chk(!ram.exists('h0300), "R9", "busy-time address untouched",
          int'(ram.exists('h0300)), 0);
      chk(rsp_rdata == 8'h81, "R9", "no read from busy-time request",
          int'(rsp_rdata), 'h81);

      // R8: one done pulse per access
      chk(done_seen == txn_count, "R8", "done pulse count", done_seen, txn_count);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (40000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL [R8] watchdog actual=%0h expected=%0h", 1, 0);
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule